// File: doc/BRIEF.md
# Per-Stream Frame Buffer Tracker

This block keeps the books for a small fixed pool of picture buffers belonging to one elementary stream's share of the frame store. One instance serves each stream, and the frame store is split into two or four such shares. When a new picture starts decoding, the tracker hands out a free buffer. It keeps up to two decoded anchor pictures (I or P) as forward and backward references. It also turns decode order into display order by placing buffer indices on a display queue.

Each buffer carries two independent hold flags. The reference hold lasts while the picture may still be used for prediction. The display hold lasts from allocation until the display side reports that it has finished with the picture. A buffer returns to the pool only when both flags are clear. An anchor picture is queued for display when the next anchor starts, because every B-picture decoded between the two is shown before it. A B-picture is queued as soon as its decode finishes. A flush at end of stream releases the pending anchor for display and drops all reference holds.

The decode-start channel and the display-queue channel are valid/ready. A start is accepted only in a cycle where both `start_valid` and `start_ready` are high, and `start_type` must stay unchanged while a start is pending. The display queue presents its head while `disp_valid` is high and keeps it stable until `disp_ready` is seen. The decode-done, display-done and flush inputs are single-cycle events with no handshake.

Top module: `fbt_tracker`

## Requirements
- R1: After reset every buffer is free and no reference is held. `start_ready` is high whenever `flush` is low, and both `disp_valid` and `alloc_valid` are low.
- R2: `start_ready` is high only when no decode is in flight, at least one buffer is free and `flush` is low. A start accepted at a clock edge makes `alloc_valid` high for exactly the following cycle, with `alloc_idx` set to the lowest-numbered free buffer.
- R3: `start_type` encodes 0 = I, 1 = P, 2 = B, and 3 is handled as B. An accepted I or P start makes the new buffer the newest reference. The older reference loses its reference hold, and the previous newest reference is pushed onto the display queue in the same cycle.
- R4: A B-picture never receives a reference hold. Its buffer is pushed onto the display queue in the cycle after `dec_done` is pulsed for it.
- R5: A buffer is reallocated only after both its hold flags are clear. A `disp_done` pulse clears the display hold of buffer `disp_done_idx`. The reference hold is cleared only by a later anchor or by a flush.
- R6: `start_wait` is high while `start_valid` is high and no buffer is free. It stays high until a release frees a buffer, and `start_ready` is low whenever `start_wait` is high.
- R7: The display queue delivers indices in push order. `disp_valid` and `disp_idx` hold steady until the cycle in which `disp_ready` is high.
- R8: A `flush` pulse while no decode is in flight pushes the newest reference (if any) for display and clears every reference hold. A `flush` pulse during a decode is ignored.
- R9: A buffer whose reference hold is released by an anchor start in the same cycle that its display hold is cleared by `disp_done` is free from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Decode-start request pending |
| start_ready | output | 1 | Tracker can accept a decode start |
| start_type | input | 2 | Picture type: 0 I, 1 P, 2 or 3 B |
| start_wait | output | 1 | Request pending but no buffer free |
| alloc_valid | output | 1 | One-cycle pulse: allocation result valid |
| alloc_idx | output | $clog2(NBUF) | Buffer allocated to the new picture |
| dec_done | input | 1 | Decode of the current picture finished |
| flush | input | 1 | End-of-stream flush event |
| disp_valid | output | 1 | Display queue not empty |
| disp_ready | input | 1 | Display side takes the queue head |
| disp_idx | output | $clog2(NBUF) | Buffer index at the queue head |
| disp_done | input | 1 | Display of a buffer finished |
| disp_done_idx | input | $clog2(NBUF) | Buffer whose display finished |

## Verification
Two release paths can hit the same buffer in the same cycle. An anchor start can drop a buffer's reference hold while a display-done pulse drops its display hold. The bench provokes this by asserting a P start together with `disp_done` for the older reference. The next allocation must then return that buffer, which judges whether it was freed. A release that frees a buffer can also coincide with a start request that is waiting on a full pool. The bench judges this by sampling `start_wait` and `start_ready` before and after the display-done pulse.

// File: rtl/fbt_pkg.sv
package fbt_pkg;
  typedef enum logic [1:0] {
    PIC_I = 2'd0,
    PIC_P = 2'd1,
    PIC_B = 2'd2,
    PIC_X = 2'd3
  } pic_e;
endpackage

// File: rtl/fbt_pick.sv
module fbt_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  free_vec,
  output logic          any_free,
  output logic [IW-1:0] pick_idx
);
  always_comb begin
    pick_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_vec[i]) pick_idx = IW'(i);
    end
  end
  assign any_free = |free_vec;
endmodule

// File: rtl/fbt_hold_bank.sv
module fbt_hold_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ref_set,
  input  logic [N-1:0] ref_clr,
  input  logic [N-1:0] disp_set,
  input  logic [N-1:0] disp_clr,
  output logic [N-1:0] ref_q,
  output logic [N-1:0] disp_q,
  output logic [N-1:0] free_q
);
  for (genvar g = 0; g < N; g++) begin : g_buf
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ref_q[g]  <= 1'b0;
        disp_q[g] <= 1'b0;
      end else begin
        if (ref_set[g])       ref_q[g] <= 1'b1;
        else if (ref_clr[g])  ref_q[g] <= 1'b0;
        if (disp_set[g])      disp_q[g] <= 1'b1;
        else if (disp_clr[g]) disp_q[g] <= 1'b0;
      end
    end
  end

  assign free_q = ~ref_q & ~disp_q;

  // R5
  alloc_on_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_set & ~free_q) == '0);
endmodule

// File: rtl/fbt_dispq.sv
module fbt_dispq #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [IW-1:0] push_idx,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [IW-1:0] out_idx
);
  localparam int CW = $clog2(N + 1);

  logic [IW-1:0] mem [N];
  logic [IW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          pop;

  assign out_valid = (count != '0);
  assign out_idx   = mem[rd_ptr];
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr] <= push_idx;
        wr_ptr      <= (wr_ptr == IW'(N - 1)) ? '0 : wr_ptr + 1'b1;
      end
      if (pop) rd_ptr <= (rd_ptr == IW'(N - 1)) ? '0 : rd_ptr + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count != CW'(N)) || pop);
  // R7
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_idx)));
endmodule

// File: rtl/fbt_tracker.sv
module fbt_tracker
  import fbt_pkg::*;
#(
  parameter int NBUF = 4,
  localparam int IW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_valid,
  output logic          start_ready,
  input  logic [1:0]    start_type,
  output logic          start_wait,
  output logic          alloc_valid,
  output logic [IW-1:0] alloc_idx,
  input  logic          dec_done,
  input  logic          flush,
  output logic          disp_valid,
  input  logic          disp_ready,
  output logic [IW-1:0] disp_idx,
  input  logic          disp_done,
  input  logic [IW-1:0] disp_done_idx
);
  localparam logic [NBUF-1:0] ONE = NBUF'(1);

  logic [NBUF-1:0] ref_set, ref_clr, disp_set, disp_clr;
  logic [NBUF-1:0] ref_q, disp_q, free_q;
  logic            any_free;
  logic [IW-1:0]   pick_idx;

  logic            busy, cur_is_b;
  logic [IW-1:0]   cur_idx;
  logic            rnew_v, rold_v;
  logic [IW-1:0]   rnew_idx, rold_idx;

  logic            accept, is_anchor, flush_eff;
  logic            push;
  logic [IW-1:0]   push_idx;

  fbt_pick #(.N(NBUF), .IW(IW)) pick_i (
    .free_vec (free_q),
    .any_free (any_free),
    .pick_idx (pick_idx)
  );

  fbt_hold_bank #(.N(NBUF)) bank_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_set  (ref_set),
    .ref_clr  (ref_clr),
    .disp_set (disp_set),
    .disp_clr (disp_clr),
    .ref_q    (ref_q),
    .disp_q   (disp_q),
    .free_q   (free_q)
  );

  fbt_dispq #(.N(NBUF), .IW(IW)) queue_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_idx  (push_idx),
    .out_valid (disp_valid),
    .out_ready (disp_ready),
    .out_idx   (disp_idx)
  );

  assign start_ready = !busy && any_free && !flush;
  assign start_wait  = start_valid && !any_free;
  assign accept      = start_valid && start_ready;
  assign is_anchor   = (start_type == PIC_I) || (start_type == PIC_P);
  assign flush_eff   = flush && !busy;

  always_comb begin
    ref_set  = '0;
    ref_clr  = '0;
    disp_set = '0;
    disp_clr = '0;
    push     = 1'b0;
    push_idx = '0;
    if (accept) begin
      disp_set = ONE << pick_idx;
      if (is_anchor) begin
        ref_set = ONE << pick_idx;
        if (rold_v) ref_clr = ONE << rold_idx;
        if (rnew_v) begin
          push     = 1'b1;
          push_idx = rnew_idx;
        end
      end
    end
    if (flush_eff) begin
      ref_clr = '1;
      if (rnew_v) begin
        push     = 1'b1;
        push_idx = rnew_idx;
      end
    end
    if (dec_done && busy && cur_is_b) begin
      push     = 1'b1;
      push_idx = cur_idx;
    end
    if (disp_done) disp_clr = ONE << disp_done_idx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      cur_is_b    <= 1'b0;
      cur_idx     <= '0;
      rnew_v      <= 1'b0;
      rold_v      <= 1'b0;
      rnew_idx    <= '0;
      rold_idx    <= '0;
      alloc_valid <= 1'b0;
      alloc_idx   <= '0;
    end else begin
      alloc_valid <= accept;
      if (accept) begin
        alloc_idx <= pick_idx;
        busy      <= 1'b1;
        cur_idx   <= pick_idx;
        cur_is_b  <= !is_anchor;
      end else if (dec_done) begin
        busy <= 1'b0;
      end
      if (flush_eff) begin
        rnew_v <= 1'b0;
        rold_v <= 1'b0;
      end else if (accept && is_anchor) begin
        rold_v   <= rnew_v;
        rold_idx <= rnew_idx;
        rnew_v   <= 1'b1;
        rnew_idx <= pick_idx;
      end
    end
  end

  // R2
  alloc_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |-> $past(start_valid && start_ready));
  // R2
  alloc_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |=> !alloc_valid);
  // R6
  wait_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_wait |-> !start_ready);
  // R4
  b_never_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && cur_is_b) |-> !ref_q[alloc_idx]);
endmodule

// File: tb/fbt_tracker_tb_top.sv
module fbt_tracker_tb_top;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_valid = 1'b0, dec_done = 1'b0, flush = 1'b0;
  logic disp_ready = 1'b0, disp_done = 1'b0;
  logic [1:0] start_type = 2'd0;
  logic [IW-1:0] disp_done_idx = '0;
  logic start_ready, start_wait, alloc_valid, disp_valid;
  logic [IW-1:0] alloc_idx, disp_idx;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  fbt_tracker #(.NBUF(4)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .start_valid(start_valid), .start_ready(start_ready),
    .start_type(start_type), .start_wait(start_wait),
    .alloc_valid(alloc_valid), .alloc_idx(alloc_idx),
    .dec_done(dec_done), .flush(flush),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_idx(disp_idx),
    .disp_done(disp_done), .disp_done_idx(disp_done_idx)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_start(input logic [1:0] t, input int e, input string req);
    @(negedge clk);
    start_valid = 1'b1;
    start_type  = t;
    while (!start_ready) @(negedge clk);
    @(negedge clk);
    chk(alloc_valid && alloc_idx == IW'(e), req, int'(alloc_idx), e);
    start_valid = 1'b0;
  endtask

  task automatic do_done();
    @(negedge clk); dec_done = 1'b1;
    @(negedge clk); dec_done = 1'b0;
  endtask

  task automatic do_pop(input int e, input string req);
    @(negedge clk);
    while (!disp_valid) @(negedge clk);
    chk(disp_idx == IW'(e), req, int'(disp_idx), e);
    disp_ready = 1'b1;
    @(negedge clk); disp_ready = 1'b0;
  endtask

  task automatic do_ddone(input int i);
    @(negedge clk); disp_done = 1'b1; disp_done_idx = IW'(i);
    @(negedge clk); disp_done = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // row: {op[2:0], arg[1:0], exp[1:0]}; op 0 start, 1 done, 2 pop, 3 disp_done, 4 flush
  localparam int NV = 31;
  localparam logic [6:0] VEC [NV] = '{
    {3'd0, 2'd0, 2'd0}, {3'd1, 2'd0, 2'd0},  // R2 I -> 0
    {3'd0, 2'd1, 2'd1}, {3'd1, 2'd0, 2'd0},  // R3 P -> 1, queues 0
    {3'd0, 2'd2, 2'd2}, {3'd1, 2'd0, 2'd0},  // R4 B -> 2
    {3'd0, 2'd3, 2'd3}, {3'd1, 2'd0, 2'd0},  // R4 type 3 as B -> 3
    {3'd2, 2'd0, 2'd0}, {3'd3, 2'd0, 2'd0},  // R3 anchor 0 first
    {3'd2, 2'd0, 2'd2}, {3'd3, 2'd2, 2'd0},  // R4 B in decode order
    {3'd0, 2'd1, 2'd2}, {3'd1, 2'd0, 2'd0},  // R5 0 still ref-held, P -> 2
    {3'd2, 2'd0, 2'd3}, {3'd3, 2'd3, 2'd0},
    {3'd2, 2'd0, 2'd1}, {3'd3, 2'd1, 2'd0},  // R3 P1 after its Bs
    {3'd0, 2'd2, 2'd0}, {3'd1, 2'd0, 2'd0},  // R5 0 freed by ref release
    {3'd2, 2'd0, 2'd0}, {3'd3, 2'd0, 2'd0},
    {3'd4, 2'd0, 2'd0},                      // R8 flush queues 2
    {3'd2, 2'd0, 2'd2}, {3'd3, 2'd2, 2'd0},
    {3'd0, 2'd0, 2'd0},                      // R8 all free after flush
    {3'd4, 2'd0, 2'd0},                      // R8 flush while busy: ignored
    {3'd1, 2'd0, 2'd0},
    {3'd0, 2'd2, 2'd1}, {3'd1, 2'd0, 2'd0},
    {3'd2, 2'd0, 2'd1}                       // R8 ref 0 not queued
  };

  initial begin : watchdog
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(start_ready, "R1", int'(start_ready), 1);
    chk(!disp_valid, "R1", int'(disp_valid), 0);
    chk(!alloc_valid, "R1", int'(alloc_valid), 0);

    for (int v = 0; v < NV; v++) begin
      case (VEC[v][6:4])
        3'd0: do_start(VEC[v][3:2], int'(VEC[v][1:0]), "R2");
        3'd1: do_done();
        3'd2: do_pop(int'(VEC[v][1:0]), "R7");
        3'd3: do_ddone(int'(VEC[v][3:2]));
        default: do_flush();
      endcase
    end

    // R6 full pool makes a start wait
    do_reset();
    do_start(2'd0, 0, "R2"); do_done();
    do_start(2'd1, 1, "R2"); do_done();
    do_start(2'd1, 2, "R3"); do_done();
    do_start(2'd2, 3, "R4"); do_done();
    @(negedge clk);
    start_valid = 1'b1;
    start_type  = 2'd2;
    @(negedge clk);
    chk(start_wait, "R6", int'(start_wait), 1);
    chk(!start_ready, "R6", int'(start_ready), 0);
    chk(disp_idx == 2'd0, "R7", int'(disp_idx), 0);
    disp_ready = 1'b1;
    @(negedge clk);
    disp_ready = 1'b0;
    chk(start_wait, "R6", int'(start_wait), 1);
    disp_done = 1'b1;
    disp_done_idx = 2'd0;
    @(negedge clk);
    disp_done = 1'b0;
    chk(!start_wait && start_ready, "R6", int'(start_wait), 0);
    @(negedge clk);
    chk(alloc_valid && alloc_idx == 2'd0, "R6", int'(alloc_idx), 0);
    start_valid = 1'b0;
    do_done();
    do_pop(1, "R7");
    do_pop(3, "R7");
    do_ddone(3);
    // R9 anchor start releases ref of 1 while disp_done clears 1
    @(negedge clk);
    start_valid = 1'b1;
    start_type  = 2'd1;
    disp_done   = 1'b1;
    disp_done_idx = 2'd1;
    chk(start_ready, "R9", int'(start_ready), 1);
    @(negedge clk);
    disp_done = 1'b0;
    chk(alloc_valid && alloc_idx == 2'd3, "R9", int'(alloc_idx), 3);
    start_valid = 1'b0;
    do_done();
    do_start(2'd0, 1, "R9");
    do_done();
    do_pop(0, "R7");
    do_pop(2, "R9");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule